// File: doc/BRIEF.md
# Hamming-correcting serial receiver

This block receives asynchronous serial frames and hands out one parallel word per frame. The word is 8, 16 or 32 bits wide, as picked by a width select. In code mode, the frame carries a Hamming codeword. The receiver rebuilds the check bits from the data it received, forms a syndrome, and flips the single bit that the syndrome points at. In parity mode, the frame carries the raw data followed by one even parity bit. A mismatch in that mode is only flagged.

Bit timing comes from a 16-bit divisor. Frames are captured into a holding register when the stop bit is sampled. The correction step runs in the cycle after that. Its result is registered, so the word comes out while the next frame is already being shifted in. Back-to-back frames therefore lose no bit time to correction.

Top module: `ecc_serial_rx`

## Requirements
- R1: A falling edge on the line starts a candidate start bit. The line is sampled again after `divisor>>1` further clocks. If it is high at that point, the candidate is dropped and no word is produced.
- R2: One bit lasts `divisor+1` clocks, and `divisor` must be at least 1. After a confirmed start, each bit is sampled once per bit period. `width_sel` 0 selects 8 data bits, 1 selects 16, and 2 or 3 select 32. Width and mode are taken at the start bit.
- R3: In code mode the frame is start (0), codeword positions 1..N in ascending order, then stop (1), with N = 12, 21 or 38. Check bits sit at positions 1, 2, 4, 8, 16 and 32 (those up to N). Each check bit makes the XOR of all positions whose index shares that bit equal to 0. Data bits D0 upward fill the remaining positions in ascending order.
- R4: In code mode, a single flipped data position is corrected. The word is delivered with `fix_flag`=1.
- R5: In code mode, a syndrome that points at a check-bit position sets `fix_flag`. The data is then delivered unchanged.
- R6: In code mode, a syndrome greater than N sets `unfix_flag` with `fix_flag`=0. The data is then delivered as received.
- R7: In parity mode the frame is start, data LSB first, one even parity bit, then stop. A parity mismatch sets `par_err`, the data is delivered as received, and `fix_flag` and `unfix_flag` stay 0.
- R8: A stop bit sampled as 0 sets `frm_err`, and the word is still delivered.
- R9: Each frame yields exactly one `rx_valid` pulse, one cycle long, with its flags alongside. The pulse comes before the end of the following frame's start bit. Outside that pulse all flags are 0, and after reset no pulse appears without a frame.
- R10: Data bits above the selected width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 1 | Serial line, idle high |
| width_sel | input | 2 | Word width: 0=8, 1=16, 2/3=32 |
| ecc_en | input | 1 | 1 = Hamming code mode, 0 = even parity mode |
| divisor | input | DIV_W | Bit period minus one, in clocks |
| rx_data | output | 32 | Received (corrected) word |
| rx_valid | output | 1 | One-cycle word strobe |
| fix_flag | output | 1 | Single error corrected |
| unfix_flag | output | 1 | Syndrome out of range, not corrected |
| par_err | output | 1 | Parity mismatch in parity mode |
| frm_err | output | 1 | Stop bit sampled low |

## Verification
The bench builds the receiver with the default 16-bit divisor field. It drives short bit periods (divisor 1 to 9), so that full 38-position codewords and back-to-back runs fit in a few thousand cycles. The minimum divisor of 1 puts the mid-bit sampling point at its tightest.

Single flips are placed on data and check positions, and double flips are chosen so that their syndrome exceeds the codeword length. Together these reach all three syndrome outcomes at every width.

// File: rtl/ecc_serial_rx.sv
module ecc_serial_rx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [1:0]       width_sel,
  input  logic             ecc_en,
  input  logic [DIV_W-1:0] divisor,
  output logic [31:0]      rx_data,
  output logic             rx_valid,
  output logic             fix_flag,
  output logic             unfix_flag,
  output logic             par_err,
  output logic             frm_err
);

  localparam int CWMAX = 38;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} st_t;

  function automatic logic [5:0] frame_len(input logic [1:0] w, input logic e);
    if (e) return (w == 2'd0) ? 6'd12 : (w == 2'd1) ? 6'd21 : 6'd38;
    return (w == 2'd0) ? 6'd9 : (w == 2'd1) ? 6'd17 : 6'd33;
  endfunction

  logic [2:0]       sync;
  logic             rx_s, rx_q, fall;
  st_t              st;
  logic [DIV_W-1:0] cnt, half;
  logic [5:0]       idx, f_len, h_len;
  logic [1:0]       f_w, h_w;
  logic             f_ecc, h_ecc, h_frm, pend;
  logic [CWMAX:1]   cw, h_cw, fixed;
  logic [5:0]       syn;
  logic             in_range, pxor;
  logic [31:0]      hd, dmask, word;

  assign rx_s  = sync[1];
  assign rx_q  = sync[2];
  assign fall  = rx_q & ~rx_s;
  assign half  = divisor >> 1;
  assign f_len = frame_len(f_w, f_ecc);
  assign h_len = frame_len(h_w, h_ecc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= 3'b111;
      st    <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      f_w   <= '0;
      f_ecc <= 1'b0;
      cw    <= '0;
      h_cw  <= '0;
      h_w   <= '0;
      h_ecc <= 1'b0;
      h_frm <= 1'b0;
      pend  <= 1'b0;
    end else begin
      sync <= {sync[1:0], rxd};
      pend <= 1'b0;
      case (st)
        S_IDLE: if (fall) begin
          st    <= S_START;
          cnt   <= '0;
          f_w   <= width_sel;
          f_ecc <= ecc_en;
        end
        S_START: if (cnt >= half) begin
          cnt <= '0;
          idx <= '0;
          cw  <= '0;
          st  <= rx_s ? S_IDLE : S_BITS;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_BITS: if (cnt >= divisor) begin
          cnt <= '0;
          if (idx == f_len) begin
            st    <= S_IDLE;
            h_cw  <= cw;
            h_w   <= f_w;
            h_ecc <= f_ecc;
            h_frm <= ~rx_s;
            pend  <= 1'b1;
          end else begin
            cw[6'(idx + 6'd1)] <= rx_s;
            idx <= idx + 6'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    int k;
    syn  = '0;
    pxor = 1'b0;
    for (int p = 1; p <= CWMAX; p++) begin
      if (p <= int'(h_len) && h_cw[p]) begin
        syn  = syn ^ 6'(p);
        pxor = ~pxor;
      end
    end
    in_range = (syn != 6'd0) && (syn <= h_len);
    fixed = h_cw;
    for (int p = 1; p <= CWMAX; p++)
      if (in_range && 6'(p) == syn) fixed[p] = ~fixed[p];
    hd = '0;
    k  = 0;
    for (int p = 3; p <= CWMAX; p++) begin
      if ((p & (p - 1)) != 0) begin
        hd[k[4:0]] = fixed[p];
        k++;
      end
    end
    dmask = (h_w == 2'd0) ? 32'h0000_00FF : (h_w == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    word  = (h_ecc ? hd : h_cw[32:1]) & dmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      fix_flag   <= 1'b0;
      unfix_flag <= 1'b0;
      par_err    <= 1'b0;
      frm_err    <= 1'b0;
    end else begin
      rx_valid   <= pend;
      fix_flag   <= pend & h_ecc & in_range;
      unfix_flag <= pend & h_ecc & (syn > h_len);
      par_err    <= pend & ~h_ecc & pxor;
      frm_err    <= pend & h_frm;
      if (pend) rx_data <= word;
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9
  deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> rx_valid);

  // R9
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !(fix_flag || unfix_flag || par_err || frm_err));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(fix_flag && unfix_flag));

  // R7
  parity_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !h_ecc) |=> (!fix_flag && !unfix_flag));

  // R10
  byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && h_w == 2'd0) |=> (rx_data[31:8] == 24'd0));

endmodule

// File: tb/ecc_serial_rx_bench.sv
module ecc_serial_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [1:0]  width_sel = '0;
  logic        ecc_en = 1'b1;
  logic [15:0] divisor = 16'd9;
  logic [31:0] rx_data;
  logic        rx_valid, fix_flag, unfix_flag, par_err, frm_err;

  int checks = 0, fails = 0, valids = 0;
  bit done = 1'b0;

  logic [31:0] q_d[$];
  bit q_fix[$], q_unfix[$], q_par[$], q_frm[$];
  string q_tag[$];

  always #2 clk = ~clk;

  ecc_serial_rx u_ecc_serial_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .width_sel(width_sel), .ecc_en(ecc_en),
    .divisor(divisor), .rx_data(rx_data), .rx_valid(rx_valid), .fix_flag(fix_flag),
    .unfix_flag(unfix_flag), .par_err(par_err), .frm_err(frm_err));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      valids++;
      if (q_d.size() == 0) begin
        check(1'b0, "R9", "unexpected valid", 32'd1, 32'd0);
      end else begin
        logic [31:0] ed;
        bit ef, eu, ep, em;
        string t;
        ed = q_d.pop_front(); ef = q_fix.pop_front(); eu = q_unfix.pop_front();
        ep = q_par.pop_front(); em = q_frm.pop_front(); t = q_tag.pop_front();
        check(rx_data == ed, t, "data", rx_data, ed);
        check({fix_flag, unfix_flag, par_err, frm_err} == {ef, eu, ep, em}, t, "flags fix/unfix/par/frm",
              {28'd0, fix_flag, unfix_flag, par_err, frm_err}, {28'd0, ef, eu, ep, em});
      end
    end
  end

  // flip positions: 0 means none; ecc positions 1..N, parity positions 1..W+1
  task automatic send_frame(input int ws, input bit ecc, input logic [31:0] din,
                            input int f1, input int f2, input bit stop_bit,
                            input int div, input bit chk_prev, input string tag);
    int W, N, nb, k, nfl;
    logic [38:1] cwb;
    logic [31:0] d, ed;
    bit bits[64];
    W = (ws == 0) ? 8 : (ws == 1) ? 16 : 32;
    d = (W == 32) ? din : (din & ((32'd1 << W) - 1));
    cwb = '0;
    nfl = (f1 != 0) + (f2 != 0);
    if (ecc) begin
      N = (W == 8) ? 12 : (W == 16) ? 21 : 38;
      k = 0;
      for (int p = 1; p <= N; p++) if ((p & (p - 1)) != 0) begin cwb[p] = d[k]; k++; end
      for (int c = 1; c <= N; c = c * 2) begin
        bit par = 1'b0;
        for (int p = 1; p <= N; p++) if ((p & c) != 0 && p != c) par ^= cwb[p];
        cwb[c] = par;
      end
      if (f1 != 0) cwb[f1] = ~cwb[f1];
      if (f2 != 0) cwb[f2] = ~cwb[f2];
      nb = N;
    end else begin
      N = W + 1;
      for (int i = 0; i < W; i++) cwb[i + 1] = d[i];
      cwb[W + 1] = ^d;
      if (f1 != 0) cwb[f1] = ~cwb[f1];
      if (f2 != 0) cwb[f2] = ~cwb[f2];
      nb = N;
    end
    for (int i = 1; i <= nb; i++) bits[i - 1] = cwb[i];
    ed = '0;
    if (!ecc) begin
      for (int i = 0; i < W; i++) ed[i] = cwb[i + 1];
    end else if (nfl < 2) begin
      ed = d;
    end else begin
      k = 0;
      for (int p = 1; p <= N; p++) if ((p & (p - 1)) != 0) begin ed[k] = cwb[p]; k++; end
    end
    @(negedge clk);
    width_sel = 2'(ws); ecc_en = ecc; divisor = 16'(div);
    rxd = 1'b0;
    repeat (div + 1) @(negedge clk);
    if (chk_prev) check(q_d.size() == 0, "R9", "previous word delivered by end of start bit",
                        32'(q_d.size()), 32'd0);
    q_d.push_back(ed);
    q_fix.push_back(ecc && nfl == 1);
    q_unfix.push_back(ecc && nfl == 2);
    q_par.push_back(!ecc && (nfl % 2 == 1));
    q_frm.push_back(!stop_bit);
    q_tag.push_back(tag);
    for (int i = 0; i < nb; i++) begin
      rxd = bits[i];
      repeat (div + 1) @(negedge clk);
    end
    rxd = stop_bit;
    repeat (div + 1) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check({rx_valid, fix_flag, unfix_flag, par_err, frm_err} == 5'd0, "R9", "reset outputs",
          {27'd0, rx_valid, fix_flag, unfix_flag, par_err, frm_err}, 32'd0);
    check(rx_data == 32'd0, "R9", "reset data", rx_data, 32'd0);
    rst_n = 1'b1;
    idle(20);
    check(valids == 0, "R9", "no pulse without frame", 32'(valids), 32'd0);

    // R1 glitch shorter than half a bit
    divisor = 16'd9;
    rxd = 1'b0; @(negedge clk); rxd = 1'b1;
    idle(80);
    check(valids == 0, "R1", "glitch rejected", 32'(valids), 32'd0);

    // R2 R3 clean words at each width, R10 upper bits
    send_frame(0, 1, 32'hFFFF_FFA5, 0, 0, 1, 9, 0, "R3_w8");
    send_frame(1, 1, 32'h0000_1234, 0, 0, 1, 7, 1, "R2_w16");
    send_frame(2, 1, 32'hDEAD_BEEF, 0, 0, 1, 7, 1, "R3_w32");
    send_frame(3, 1, 32'h8001_7FFE, 0, 0, 1, 7, 1, "R2_sel3");
    send_frame(1, 1, 32'hABCD_5A5A, 0, 0, 1, 8, 1, "R10_w16");
    idle(20);
    // R4 single data flips
    send_frame(0, 1, 32'h0000_003C, 5, 0, 1, 7, 0, "R4_w8");
    send_frame(1, 1, 32'h0000_F00D, 19, 0, 1, 7, 1, "R4_w16");
    send_frame(2, 1, 32'h1357_9BDF, 37, 0, 1, 7, 1, "R4_w32");
    send_frame(2, 1, 32'h0F0F_F0F0, 3, 0, 1, 7, 1, "R4_w32lo");
    // R5 check-bit flips
    send_frame(0, 1, 32'h0000_0081, 8, 0, 1, 7, 1, "R5_w8");
    send_frame(2, 1, 32'hCAFE_0001, 32, 0, 1, 7, 1, "R5_w32");
    send_frame(1, 1, 32'h0000_7777, 1, 0, 1, 7, 1, "R5_w16");
    // R6 double flips with syndrome beyond N
    send_frame(0, 1, 32'h0000_00C3, 5, 8, 1, 7, 1, "R6_w8");
    send_frame(1, 1, 32'h0000_2468, 6, 17, 1, 7, 1, "R6_w16");
    send_frame(2, 1, 32'h7654_3210, 7, 32, 1, 7, 1, "R6_w32");
    idle(20);
    // R7 parity mode
    send_frame(0, 0, 32'h0000_0055, 0, 0, 1, 9, 0, "R7_w8");
    send_frame(1, 0, 32'h0000_BEEF, 4, 0, 1, 7, 1, "R7_w16");
    send_frame(2, 0, 32'h1234_5678, 33, 0, 1, 7, 1, "R7_w32par");
    send_frame(0, 0, 32'h0000_0011, 2, 6, 1, 7, 1, "R7_w8dbl");
    idle(20);
    // R8 stop bit low
    send_frame(1, 1, 32'h0000_A5A5, 0, 0, 0, 7, 0, "R8_ecc");
    idle(20);
    send_frame(0, 0, 32'h0000_00F0, 0, 0, 0, 7, 0, "R8_par");
    idle(20);
    // R2 minimum divisor
    send_frame(0, 1, 32'h0000_0096, 0, 0, 1, 1, 0, "R2_div1");
    idle(10);
    send_frame(2, 1, 32'h5555_AAAA, 12, 0, 1, 1, 0, "R2_div1_w32");
    idle(40);
    check(q_d.size() == 0, "R9", "all words delivered", 32'(q_d.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R9", "watchdog expired", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule